// File: doc/BRIEF.md
# SD Host Interrupt Status Aggregator

This block collects the interrupt causes of an SD host controller into one 32-bit status word and drives a single interrupt request line. Single-cycle event pulses from the command, data, DMA, buffer and boot logic are latched into status bits. Each cause is gated by a status-enable mask. Software clears a latched bit by writing 1 to it. A second mask, the signal-enable mask, selects which status bits reach the interrupt line.

Three status bits are not plain latched events. The card-interrupt bit follows a live level input. The error-summary bit is the OR of the latched error bits. The insertion and removal bits are raised by edges of the card-present state, which the block derives from the inverted, already debounced card-detect pin. A software "reset all" input clears status and both masks. It does not touch the card-present tracking, so a reset cannot cause a false insertion or removal event.

Top module: `sdhc_irq_hub`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), status, status-enable and signal-enable all read 0. card_present_o equals the inverse of cd_pin_n_i, and no insertion or removal bit is raised at reset release.
- R2: An evt_i pulse on a latched bit position (0-5, 9, 10, 16-25, 28, 29) sets that status bit at the next clock edge only if the matching status-enable bit is 1. A pulse seen while the enable bit is 0 is lost and does not appear when the enable bit is set later.
- R3: A write with wr_sel_i = 2'b00 clears every latched status bit whose wr_data_i bit is 1 and leaves the bits written with 0 unchanged. Writing bits 8 and 15 has no effect.
- R4: When an enabled event and a clearing write hit the same status bit in the same cycle, the bit is 1 afterwards.
- R5: Status bit 15 is 1 exactly when at least one of the latched error bits 16-25, 28, 29 is 1.
- R6: Status bit 8 follows card_irq_i in the same cycle while status-enable bit 8 is 1, is 0 otherwise, and is never latched.
- R7: card_present_o is the inverse of cd_pin_n_i, registered once. A 0-to-1 change of card presence sets status bit 6 and a 1-to-0 change sets status bit 7, each gated by its status-enable bit. evt_i bits 6 and 7 have no effect.
- R8: A write with wr_sel_i = 2'b01 loads the status-enable mask and one with 2'b10 loads the signal-enable mask. Only implemented positions (mask 32'h33FF_87FF) are stored and all other bits read 0. wr_sel_i = 2'b11 writes nothing, and without a write a mask holds its value.
- R9: irq_o is 1 in the same cycle exactly when some status bit and the same signal-enable bit are both 1.
- R10: sw_reset_all_i high at a clock edge clears status and both masks and overrides any event or write in that cycle. It leaves card_present_o tracking the pin.
- R11: evt_i bits 8, 11-15, 26, 27, 30 and 31 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_reset_all_i | input | 1 | Software reset-all: clears status and masks |
| evt_i | input | 32 | Event pulses, one per status bit position |
| card_irq_i | input | 1 | Live card interrupt level |
| cd_pin_n_i | input | 1 | Debounced card-detect pin, low when a card is present |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 00 status (write-1-to-clear), 01 status-enable, 10 signal-enable, 11 none |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Status word |
| stat_en_o | output | 32 | Status-enable mask |
| sig_en_o | output | 32 | Signal-enable mask |
| card_present_o | output | 1 | Registered card-present state |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives single-bit event pulses and a wide burst covering the normal and error groups. One burst uses every unimplemented position, which tells real latching apart from leakage into reserved bits. Clear writes are tried partial, full, and coinciding with an event on the same bit, so a design where the clear wins is caught. Pin toggles with both enable states separate edge-driven insertion and removal from plain pin copying and from the ignored evt_i bits 6 and 7. A reset-all arriving together with a pin edge and pending events shows that the masks are cleared while presence tracking goes on.

// File: rtl/sdhc_irq_pkg.sv
// Package: shared constants for the SD host interrupt aggregator.
// Bit positions are fixed by software's view of the status word.
package sdhc_irq_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned POS_INS  = 6;
    localparam int unsigned POS_REM  = 7;
    localparam int unsigned POS_CARD = 8;
    localparam int unsigned POS_ESUM = 15;

    // Latched cause bits: normal 0-7, 9, 10; errors 16-25, 28, 29.
    localparam logic [REG_W-1:0] LATCH_BITS = 32'h33FF_06FF;
    localparam logic [REG_W-1:0] ERR_BITS   = 32'h33FF_0000;
    localparam logic [REG_W-1:0] IMPL_BITS  =
        LATCH_BITS | (32'h1 << POS_CARD) | (32'h1 << POS_ESUM);
    // Latched bits fed straight from evt_i (insertion/removal come from card detect).
    localparam logic [REG_W-1:0] EVT_BITS   =
        LATCH_BITS & ~((32'h1 << POS_INS) | (32'h1 << POS_REM));

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'b00,
        SEL_STAT_EN = 2'b01,
        SEL_SIG_EN  = 2'b10,
        SEL_NONE    = 2'b11
    } wr_sel_e;
endpackage

// File: rtl/sdhc_irq_cd_track.sv
// Module: card-presence tracker.
// Registers the inverted card-detect pin and flags presence edges.
// Assumes the pin is already debounced and synchronous to clk. The register
// follows the pin even during reset, so reset release never yields an edge.
module sdhc_irq_cd_track (
    input  logic clk,
    input  logic rst_n,
    input  logic cd_pin_n_i,
    output logic present_o,
    output logic ins_o,
    output logic rem_o
);
    logic now_present;
    logic present_q;

    assign now_present = ~cd_pin_n_i;

    // Track the pin every cycle, including reset and software reset.
    always_ff @(posedge clk) begin
        present_q <= now_present;
    end

    assign present_o = present_q;
    assign ins_o     = now_present & ~present_q;
    assign rem_o     = ~now_present & present_q;

    assert_ins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_o |=> present_o);
    assert_rem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rem_o |=> !present_o);
endmodule

// File: rtl/sdhc_irq_mask_reg.sv
// Module: one enable-mask register.
// Stores only the implemented bit positions; cleared by reset and reset-all.
// Assumes wr_i is already decoded for this register by the parent.
module sdhc_irq_mask_reg #(
    parameter int unsigned DW = 32,
    parameter logic [DW-1:0] IMPL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] q_o
);
    logic [DW-1:0] q;

    // Load masked write data, clear on either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            q <= '0;
        end else if (wr_i) begin
            q <= wr_data_i & IMPL;
        end
    end

    assign q_o = q;

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q_o == '0));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !clr_i) |=> $stable(q_o));
    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> ((q_o & ~IMPL) == '0));
endmodule

// File: rtl/sdhc_irq_status_bank.sv
// Module: status word.
// Latched bits are set by enabled causes and cleared by write-1; set wins.
// The card bit is a live gated level and the summary bit ORs the error bits.
// Assumes set_i holds one-cycle pulses and w1c_i is zero outside status writes.
module sdhc_irq_status_bank #(
    parameter int unsigned   DW         = 32,
    parameter logic [DW-1:0] LATCH_BITS = '0,
    parameter logic [DW-1:0] ERR_BITS   = '0,
    parameter int unsigned   CARD_POS   = 8,
    parameter int unsigned   SUM_POS    = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all_i,
    input  logic [DW-1:0] set_i,
    input  logic [DW-1:0] en_i,
    input  logic [DW-1:0] w1c_i,
    input  logic          card_lvl_i,
    output logic [DW-1:0] status_o
);
    logic [DW-1:0] q;
    logic [DW-1:0] gated_set;

    assign gated_set = set_i & en_i;

    for (genvar k = 0; k < DW; k++) begin : g_bit
        if (LATCH_BITS[k]) begin : g_flop
            logic r;
            // One sticky cause bit: enabled set beats write-1 clear.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_all_i) begin
                    r <= 1'b0;
                end else begin
                    r <= gated_set[k] | (r & ~w1c_i[k]);
                end
            end
            assign q[k] = r;
        end else begin : g_tie
            assign q[k] = 1'b0;
        end
    end

    // Merge the derived bits into the latched word.
    always_comb begin
        status_o           = q;
        status_o[CARD_POS] = card_lvl_i & en_i[CARD_POS];
        status_o[SUM_POS]  = |(q & ERR_BITS);
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all_i |=> ((q & $past(gated_set & LATCH_BITS)) == $past(gated_set & LATCH_BITS)));
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all_i |=> ((q & ~$past(q) & ~$past(gated_set)) == '0));
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i && ((gated_set & w1c_i & LATCH_BITS) != '0))
        |=> ((q & $past(gated_set & w1c_i & LATCH_BITS)) == $past(gated_set & w1c_i & LATCH_BITS)));
    assert_err_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i && ((gated_set & ERR_BITS) != '0)) |=> status_o[SUM_POS]);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (q == '0));
endmodule

// File: rtl/sdhc_irq_hub.sv
// Module: top of the SD host interrupt aggregator.
// Decodes register writes, routes card-detect edges into the status word,
// and ORs the signal-enabled status bits onto irq_o.
// Assumes all inputs are synchronous to clk; evt_i bits are one-cycle pulses.
module sdhc_irq_hub
    import sdhc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset_all_i,
    input  logic [REG_W-1:0] evt_i,
    input  logic             card_irq_i,
    input  logic             cd_pin_n_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] stat_en_o,
    output logic [REG_W-1:0] sig_en_o,
    output logic             card_present_o,
    output logic             irq_o
);
    logic             hit_status;
    logic             hit_stat_en;
    logic             hit_sig_en;
    logic             ins_edge;
    logic             rem_edge;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] w1c_vec;

    assign hit_status  = wr_en_i && (wr_sel_i == SEL_STATUS);
    assign hit_stat_en = wr_en_i && (wr_sel_i == SEL_STAT_EN);
    assign hit_sig_en  = wr_en_i && (wr_sel_i == SEL_SIG_EN);
    assign w1c_vec     = hit_status ? wr_data_i : '0;

    sdhc_irq_cd_track u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cd_pin_n_i (cd_pin_n_i),
        .present_o  (card_present_o),
        .ins_o      (ins_edge),
        .rem_o      (rem_edge)
    );

    // Build the cause vector: filtered event pulses plus card-detect edges.
    always_comb begin
        set_vec          = evt_i & EVT_BITS;
        set_vec[POS_INS] = ins_edge;
        set_vec[POS_REM] = rem_edge;
    end

    sdhc_irq_mask_reg #(.DW(REG_W), .IMPL(IMPL_BITS)) u_stat_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (sw_reset_all_i),
        .wr_i      (hit_stat_en),
        .wr_data_i (wr_data_i),
        .q_o       (stat_en_o)
    );

    sdhc_irq_mask_reg #(.DW(REG_W), .IMPL(IMPL_BITS)) u_sig_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (sw_reset_all_i),
        .wr_i      (hit_sig_en),
        .wr_data_i (wr_data_i),
        .q_o       (sig_en_o)
    );

    sdhc_irq_status_bank #(
        .DW         (REG_W),
        .LATCH_BITS (LATCH_BITS),
        .ERR_BITS   (ERR_BITS),
        .CARD_POS   (POS_CARD),
        .SUM_POS    (POS_ESUM)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all_i  (sw_reset_all_i),
        .set_i      (set_vec),
        .en_i       (stat_en_o),
        .w1c_i      (w1c_vec),
        .card_lvl_i (card_irq_i),
        .status_o   (status_o)
    );

    // Request line: any status bit that is also signal-enabled.
    assign irq_o = |(status_o & sig_en_o);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_en_o == '0) |-> !irq_o);
    assert_card_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_en_o[POS_CARD] |-> !status_o[POS_CARD]);
endmodule

// File: tb/tb_sdhc_irq_hub.sv
// Bench: behavioural reference model of the status word, compared each cycle.
module tb_sdhc_irq_hub;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_reset_all_i;
    logic [31:0] evt_i;
    logic        card_irq_i;
    logic        cd_pin_n_i;
    logic        wr_en_i;
    logic [1:0]  wr_sel_i;
    logic [31:0] wr_data_i;
    logic [31:0] status_o, stat_en_o, sig_en_o;
    logic        card_present_o, irq_o;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    // Model state
    logic [31:0] m_st, m_se, m_sg;
    logic        m_pres;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdhc_irq_hub dut (
        .clk(clk), .rst_n(rst_n), .sw_reset_all_i(sw_reset_all_i),
        .evt_i(evt_i), .card_irq_i(card_irq_i), .cd_pin_n_i(cd_pin_n_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .status_o(status_o), .stat_en_o(stat_en_o), .sig_en_o(sig_en_o),
        .card_present_o(card_present_o), .irq_o(irq_o)
    );

    function automatic bit is_latched(int b);
        return (b <= 7) || (b == 9) || (b == 10) ||
               (b >= 16 && b <= 25) || (b == 28) || (b == 29);
    endfunction

    function automatic bit is_err(int b);
        return (b >= 16 && b <= 25) || (b == 28) || (b == 29);
    endfunction

    function automatic bit is_impl(int b);
        return is_latched(b) || (b == 8) || (b == 15);
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] s = m_st;
        bit any_err = 1'b0;
        for (int b = 0; b < 32; b++) if (is_err(b) && m_st[b]) any_err = 1'b1;
        s[8]  = card_irq_i & m_se[8];
        s[15] = any_err;
        return s;
    endfunction

    // Advance the model by one clock edge using the inputs present at that edge.
    task automatic model_edge();
        logic now_p;
        logic ins, rem;
        logic [31:0] nst;
        now_p = ~cd_pin_n_i;
        if (!rst_n) begin
            m_st = '0; m_se = '0; m_sg = '0; m_pres = now_p;
            return;
        end
        ins = now_p && !m_pres;
        rem = !now_p && m_pres;
        m_pres = now_p;
        if (sw_reset_all_i) begin
            m_st = '0; m_se = '0; m_sg = '0;
            return;
        end
        nst = m_st;
        for (int b = 0; b < 32; b++) begin
            bit src, clr;
            if (!is_latched(b)) begin
                nst[b] = 1'b0;
                continue;
            end
            src = (b == 6) ? ins : (b == 7) ? rem : evt_i[b];
            clr = wr_en_i && (wr_sel_i == 2'b00) && wr_data_i[b];
            if (src && m_se[b]) nst[b] = 1'b1;
            else if (clr)       nst[b] = 1'b0;
        end
        m_st = nst;
        if (wr_en_i && wr_sel_i == 2'b01)
            for (int b = 0; b < 32; b++) m_se[b] = wr_data_i[b] & is_impl(b);
        if (wr_en_i && wr_sel_i == 2'b10)
            for (int b = 0; b < 32; b++) m_sg[b] = wr_data_i[b] & is_impl(b);
    endtask

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%08h expected=%08h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // One clock: update model at the edge, compare at the falling edge, idle pulses.
    task automatic cyc();
        logic [31:0] es;
        bit eirq;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        es = exp_status();
        eirq = |(es & m_sg);
        cmp("status", status_o, es);
        cmp("stat_en", stat_en_o, m_se);
        cmp("sig_en", sig_en_o, m_sg);
        cmp("present", {31'd0, card_present_o}, {31'd0, m_pres});
        cmp("irq", {31'd0, irq_o}, {31'd0, eirq});
        evt_i = '0; wr_en_i = 1'b0; wr_sel_i = 2'b11; wr_data_i = '0; sw_reset_all_i = 1'b0;
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        cyc();
    endtask

    task automatic pulse(logic [31:0] e);
        evt_i = e;
        cyc();
    endtask

    initial begin
        rst_n = 1'b0; sw_reset_all_i = 1'b0; evt_i = '0; card_irq_i = 1'b0;
        cd_pin_n_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = 2'b11; wr_data_i = '0;
        m_st = '0; m_se = '0; m_sg = '0; m_pres = 1'b0;
        // R1: reset state with a card present; no edge flagged at release
        cur_req = "R1";
        evt_i = 32'hFFFF_FFFF;
        repeat (3) cyc();
        rst_n = 1'b1;
        wr(2'b01, 32'hFFFF_FFFF);
        cyc();
        // R8: masks keep only implemented bits; sel 11 writes nothing
        cur_req = "R8";
        wr(2'b10, 32'hFFFF_FFFF);
        wr(2'b11, 32'h0000_0000);
        wr(2'b10, 32'h0000_0000);
        cyc();
        // R2: single and wide event patterns
        cur_req = "R2";
        pulse(32'h0000_0001);
        pulse(32'h0000_0600);
        pulse(32'h0000_003E);
        // R3: partial and full write-1-to-clear; bits 8/15 unaffected by writes
        cur_req = "R3";
        wr(2'b00, 32'h0000_0005);
        card_irq_i = 1'b1;
        wr(2'b00, 32'h0000_8100);
        wr(2'b00, 32'hFFFF_FFFF);
        card_irq_i = 1'b0;
        cyc();
        // R5: error summary follows the error bits
        cur_req = "R5";
        pulse(32'h0001_0000);
        pulse(32'h2000_0000);
        wr(2'b00, 32'h0001_0000);
        wr(2'b00, 32'h2000_0000);
        pulse(32'h03FF_0000);
        wr(2'b00, 32'hFFFF_FFFF);
        // R4: event and clear on the same bit in the same cycle
        cur_req = "R4";
        pulse(32'h0000_0002);
        evt_i = 32'h0000_0002; wr(2'b00, 32'h0000_0002);
        evt_i = 32'h0010_0000; wr(2'b00, 32'h0010_0002);
        wr(2'b00, 32'hFFFF_FFFF);
        // R6: live card interrupt level, gated by its enable
        cur_req = "R6";
        card_irq_i = 1'b1; cyc();
        card_irq_i = 1'b0; cyc();
        card_irq_i = 1'b1;
        wr(2'b01, 32'hFFFF_FEFF);
        cyc();
        wr(2'b01, 32'hFFFF_FFFF);
        card_irq_i = 1'b0; cyc();
        // R7: presence edges; evt_i 6/7 ignored
        cur_req = "R7";
        pulse(32'h0000_00C0);
        cd_pin_n_i = 1'b1; cyc(); cyc();
        cd_pin_n_i = 1'b0; cyc(); cyc();
        wr(2'b00, 32'h0000_00C0);
        wr(2'b01, 32'hFFFF_FF3F);
        cd_pin_n_i = 1'b1; cyc();
        cd_pin_n_i = 1'b0; cyc();
        wr(2'b01, 32'hFFFF_FFFF);
        // R9: request line under different signal masks
        cur_req = "R9";
        wr(2'b10, 32'h0000_0001);
        pulse(32'h0000_0002);
        pulse(32'h0000_0001);
        wr(2'b00, 32'h0000_0001);
        wr(2'b10, 32'h0000_0100);
        card_irq_i = 1'b1; cyc();
        card_irq_i = 1'b0; cyc();
        wr(2'b10, 32'h0000_8000);
        pulse(32'h0200_0000);
        wr(2'b00, 32'hFFFF_FFFF);
        // R2: a cause seen while disabled is not recovered by enabling later
        cur_req = "R2";
        wr(2'b01, 32'h0000_0000);
        pulse(32'h0000_0010);
        wr(2'b01, 32'hFFFF_FFFF);
        cyc();
        // R11: unimplemented event positions have no effect
        cur_req = "R11";
        wr(2'b10, 32'hFFFF_FFFF);
        pulse(32'hCC00_F900);
        cyc();
        // R10: reset-all beats pending events and writes; presence still tracked
        cur_req = "R10";
        pulse(32'h0000_0001);
        sw_reset_all_i = 1'b1; evt_i = 32'h0000_0002; cd_pin_n_i = 1'b1;
        wr(2'b01, 32'hFFFF_FFFF);
        cyc();
        wr(2'b01, 32'hFFFF_FFFF);
        cd_pin_n_i = 1'b0; cyc(); cyc();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule